// File: doc/BRIEF.md
# Successive-Approximation Bit Sequencer

This block is the digital control of a successive-approximation converter. A start request loads a trial code with only its top bit set. The code goes to an external DAC, and an external comparator weighs it against the held analog input. Each clock, the comparator's differential result decides whether the bit under test stays set or is dropped. The next lower bit is then raised, so the search runs from the most significant bit down to the least significant bit.

A one-hot shift register marks the bit under test. That marker enables the capture flop of that bit alone. The comparator pair passes through a set/reset decision stage, which turns the two rails into one keep-or-clear decision. The stage falls back to a fixed safe decision when the rails do not disagree. Once the lowest bit is settled, one further clock copies the finished code to the result register and raises a single-cycle completion pulse.

The resolution is a parameter, with a default of 10 bits. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `sar_seq_top`

## Requirements
- R1: While reset is held and once it is released, `trial_o`, `code_o` and `eoc_o` are all zero until a conversion is started.
- R2: A `start_i` sampled high while idle makes `trial_o` equal to a 1 in bit RES-1 and 0 in every lower bit on the following cycle.
- R3: A comparison with `cmp_pos_i`=1 and `cmp_neg_i`=0 (DAC above the held input) clears the bit under test at the next clock.
- R4: A comparison with `cmp_neg_i`=1 and `cmp_pos_i`=0 keeps the bit under test at 1. Both rails high, or both low, also keep it at 1, because the decision stage falls back to its reset state.
- R5: Exactly one bit is tested per clock, from bit RES-1 down to bit 0. After a bit is settled, the next lower bit reads 1 in `trial_o`, and the settled bits do not change for the rest of the conversion.
- R6: `eoc_o` is a one-cycle pulse, high during the cycle after the (RES+1)-th clock edge that follows the edge sampling `start_i`. In that cycle `code_o` carries the finished code, and `code_o` holds that value until the next pulse.
- R7: A `start_i` that arrives while a conversion is running or being presented is ignored. The running conversion finishes unchanged.
- R8: With an ideal comparator (`cmp_pos_i` high exactly when the trial code is greater than the input level), the finished code equals the input level for every level from 0 to 2^RES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin a conversion, taken only while idle |
| cmp_pos_i | input | 1 | Comparator rail: DAC level above held input |
| cmp_neg_i | input | 1 | Comparator rail: DAC level below held input |
| trial_o | output | RES | Trial code driven to the DAC |
| code_o | output | RES | Finished conversion result |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The assertions check the following on every cycle:
- the seeding of the top bit after an accepted start;
- that the test marker is never more than one-hot and moves down one position per clock;
- that the bit under test is cleared or kept in line with the comparator rails;
- that the completion pulse is one cycle wide and matches the trial code;
- that the result stays stable between pulses.

Only the bench's scenarios can show the following:
- that the search converges on the right value for every input level;
- that both-rails-high and both-rails-low inputs yield an all-ones code;
- that starts arriving mid-conversion leave the result untouched.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // Sequencer phase: waiting, resolving bits, presenting the result.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_SHOW = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/sar_onehot_ring.sv
module sar_onehot_ring #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           adv_i,
  output logic [RES-1:0] ring_o,
  output logic           last_o
);
  localparam logic [RES-1:0] SEED = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] ring_q, ring_d;
  logic           ring_en;

  assign ring_en = load_i | adv_i;

  always_comb begin
    if (load_i) ring_d = SEED;
    else        ring_d = ring_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ring_q <= '0;
    else if (ring_en) ring_q <= ring_d;
  end

  assign ring_o = ring_q;
  assign last_o = ring_q[0];
endmodule

// File: rtl/sar_nand_latch.sv
// Set/reset decision stage fed by the two comparator rails. A rail pair
// that disagrees sets or resets it. A pair that agrees leaves it in its
// reset state, "keep", so a stale or undecided result never drops a bit.
module sar_nand_latch (
  input  logic pos_i,
  input  logic neg_i,
  output logic keep_o
);
  logic set_n, rst_n_l;

  assign set_n   = ~(pos_i & ~neg_i);
  assign rst_n_l = ~(neg_i & ~pos_i);
  // Clear only when the set side alone is active.
  assign keep_o  = set_n | ~rst_n_l;
endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic cap_i,
  input  logic d_i,
  output logic q_o
);
  logic q_q, q_d, q_en;

  assign q_en = clr_i | cap_i;
  assign q_d  = clr_i ? 1'b0 : d_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           cmp_pos_i,
  input  logic           cmp_neg_i,
  output logic [RES-1:0] trial_o,
  output logic [RES-1:0] code_o,
  output logic           eoc_o
);
  import sar_seq_pkg::*;

  logic           core_rst_n;
  sar_phase_e     phase_q, phase_d;
  logic           load, adv, last, keep;
  logic [RES-1:0] ring_w, cap_w;
  logic [RES-1:0] code_q;
  logic           code_en;
  logic           eoc_q, eoc_d;

  sar_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (core_rst_n)
  );

  assign load = (phase_q == PH_IDLE) & start_i;
  assign adv  = (phase_q == PH_RUN);

  sar_onehot_ring #(.RES(RES)) u_ring (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .load_i (load),
    .adv_i  (adv),
    .ring_o (ring_w),
    .last_o (last)
  );

  sar_nand_latch u_latch (
    .pos_i  (cmp_pos_i),
    .neg_i  (cmp_neg_i),
    .keep_o (keep)
  );

  for (genvar i = 0; i < RES; i++) begin : g_bit
    sar_bit_cell u_cell (
      .clk   (clk),
      .rst_n (core_rst_n),
      .clr_i (load),
      .cap_i (adv & ring_w[i]),
      .d_i   (keep),
      .q_o   (cap_w[i])
    );
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_RUN;
      PH_RUN:  if (last)    phase_d = PH_SHOW;
      PH_SHOW:              phase_d = PH_IDLE;
      default:              phase_d = PH_IDLE;
    endcase
  end

  assign code_en = (phase_q == PH_SHOW);
  assign eoc_d   = (phase_q == PH_SHOW);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      phase_q <= PH_IDLE;
      eoc_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      eoc_q   <= eoc_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  code_q <= '0;
    else if (code_en) code_q <= cap_w;
  end

  assign trial_o = cap_w | ring_w;
  assign code_o  = code_q;
  assign eoc_o   = eoc_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES = 10
) (
  input logic           clk,
  input logic           core_rst_n,
  input logic [1:0]     phase,
  input logic           start_i,
  input logic           cmp_pos_i,
  input logic           cmp_neg_i,
  input logic [RES-1:0] ring,
  input logic [RES-1:0] trial_o,
  input logic [RES-1:0] code_o,
  input logic           eoc_o
);
  localparam logic [RES-1:0] SEED = {1'b1, {(RES-1){1'b0}}};
  localparam logic [1:0] P_IDLE = 2'd0;
  localparam logic [1:0] P_RUN  = 2'd1;

  a_r2_seed: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase == P_IDLE && start_i) |=> (trial_o == SEED));

  a_r5_onehot: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0(ring));

  a_r5_step: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase == P_RUN && !ring[0]) |=> (ring == ($past(ring) >> 1)));

  a_r3_clear: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase == P_RUN && cmp_pos_i && !cmp_neg_i) |=> ((trial_o & $past(ring)) == '0));

  a_r4_keep: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase == P_RUN && !(cmp_pos_i && !cmp_neg_i)) |=> ((trial_o & $past(ring)) == $past(ring)));

  a_r6_pulse: assert property (@(posedge clk) disable iff (!core_rst_n)
    eoc_o |=> !eoc_o);

  a_r6_match: assert property (@(posedge clk) disable iff (!core_rst_n)
    eoc_o |-> (code_o == trial_o));

  a_r6_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    !eoc_o |-> $stable(code_o));
endmodule

bind sar_seq_top sar_seq_chk #(.RES(RES)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .phase      (phase_q),
  .start_i    (start_i),
  .cmp_pos_i  (cmp_pos_i),
  .cmp_neg_i  (cmp_neg_i),
  .ring       (ring_w),
  .trial_o    (trial_o),
  .code_o     (code_o),
  .eoc_o      (eoc_o)
);

// File: tb/sar_seq_top_test.sv
module sar_seq_top_test;
  localparam int  RES   = 10;
  localparam time T_CLK = 10;
  localparam int  FULL  = (1 << RES) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_pos, cmp_neg;
  logic [RES-1:0] trial, code;
  logic eoc;

  int vin = 0, mode = 0;
  int n_chk = 0, n_err = 0, cyc = 0;
  int m_phase = 0, m_bit = 0, m_trial = 0, m_code = 0, m_eoc = 0;

  always #(T_CLK/2) clk = ~clk;

  // Comparator model: 0 ideal, 1 both rails high, 2 both low, 3 stuck "above".
  always @* begin
    case (mode)
      0: begin cmp_pos = (int'(trial) > vin); cmp_neg = !(int'(trial) > vin); end
      1: begin cmp_pos = 1'b1; cmp_neg = 1'b1; end
      2: begin cmp_pos = 1'b0; cmp_neg = 1'b0; end
      default: begin cmp_pos = 1'b1; cmp_neg = 1'b0; end
    endcase
  end

  sar_seq_top #(.RES(RES)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .cmp_pos_i (cmp_pos),
    .cmp_neg_i (cmp_neg),
    .trial_o   (trial),
    .code_o    (code),
    .eoc_o     (eoc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle reference model, compared then stepped at each falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(trial) == m_trial, "R5 trial code", int'(trial), m_trial);
      chk(int'(code) == m_code, "R6 result code", int'(code), m_code);
      chk(int'(eoc) == m_eoc, "R6 end pulse", int'(eoc), m_eoc);
      if (m_phase == 2) begin
        m_code = m_trial; m_eoc = 1; m_phase = 0;
      end else begin
        m_eoc = 0;
        if (m_phase == 0) begin
          if (start) begin m_trial = 1 << (RES-1); m_bit = RES-1; m_phase = 1; end
        end else begin
          if (cmp_pos && !cmp_neg) m_trial = m_trial & ~(1 << m_bit);
          if (m_bit > 0) begin m_bit--; m_trial = m_trial | (1 << m_bit); end
          else m_phase = 2;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic run(input int level, input int md, input bit extra, input int exp, input string tag);
    vin = level; mode = md;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    chk(int'(trial) == (1 << (RES-1)), "R2 seed", int'(trial), 1 << (RES-1));
    if (extra) begin
      repeat (3) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;   // sampled mid-run: R7 ignored
      repeat (RES-3) @(posedge clk);
    end else begin
      repeat (RES+1) @(posedge clk);
    end
    #1;
    chk(eoc == 1'b1, tag, int'(eoc), 1);
    chk(int'(code) == exp, tag, int'(code), exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(trial == '0, "R1 trial in reset", int'(trial), 0);
    chk(code == '0, "R1 code in reset", int'(code), 0);
    chk(eoc == 1'b0, "R1 eoc in reset", int'(eoc), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(trial == '0 && code == '0 && !eoc, "R1 after release", int'(trial), 0);

    for (int v = 0; v <= FULL; v++) run(v, 0, 1'b0, v, "R8 ideal code");
    run(0, 3, 1'b0, 0, "R3 all cleared");
    run(5, 1, 1'b0, FULL, "R4 both rails high");
    run(5, 2, 1'b0, FULL, "R4 both rails low");
    run(FULL, 0, 1'b0, FULL, "R4 all kept");
    run(357, 0, 1'b1, 357, "R7 late start");
    run(FULL, 0, 1'b1, FULL, "R7 late start top");
    run(1, 0, 1'b1, 1, "R7 late start low");
    mode = 0;
    repeat (5) @(posedge clk);
    #1;
    chk(int'(code) == 1, "R6 hold when idle", int'(code), 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule